// File: doc/BRIEF.md
# Arbitrary-Sequence Synchronous Counter

This block is a 4-bit state register that steps through a fixed, non-binary sequence and then repeats it. Next-state logic, not an adder, decides each next state. All state bits change on the same falling clock edge, so the bits never ripple. A one-bit mode select chooses between two sequences:

- a 3-bit permutation, 6, 1, 2, 4, 7, 3, 5;
- a 4-bit stride-of-two walk, 0, 2, 4, 6, 8, 10, 12, 14.

The permutation is built from JK-style set/clear terms and the stride walk from T-style toggle terms.

Codes outside the active sequence are free choices when the logic is minimised. In hardware, though, each of them leads back into the sequence within one edge, so the counter cannot lock up. An enable pauses counting. A start flag marks the first element of the active sequence, so a consumer can use the block as a sequence generator or as a divide-by-7 or divide-by-8 tick source.

Top module: `seq_counter`

## Requirements
- R1: With mode_i = 0, each enabled falling edge advances state_o through 6, 1, 2, 4, 7, 3, 5 and from 5 back to 6.
- R2: With mode_i = 1, each enabled falling edge advances state_o through 0, 2, 4, 6, 8, 10, 12, 14 and from 14 back to 0.
- R3: In mode 0, the next state of any code outside the permutation (0 and 8 to 15) is 6.
- R4: In mode 1, the next state of any odd code is the next higher even code, and 15 goes to 0.
- R5: While rst_ni is low, state_o is the first element of the sequence selected by mode_i (6 for mode 0, 0 for mode 1), independent of the clock.
- R6: On an edge with en_i low and mode_i unchanged, state_o keeps its value.
- R7: When mode_i differs from the mode in use, the next falling edge loads the first element of the new sequence, whatever en_i is.
- R8: start_o is 1 exactly while state_o equals the first element of the active sequence.
- R9: state_o changes only on falling edges of clk_i; a rising edge leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the state updates on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| mode_i | input | 1 | Sequence select: 0 for the permutation, 1 for the even stride |
| state_o | output | 4 | Current state; bit 3 is always 0 in mode 0 |
| start_o | output | 1 | High while the state is the first element of the active sequence |

## Verification
The assertions check on every edge that:
- a mode-0 edge lands on a nonzero code below 8;
- a mode-1 edge lands on an even code;
- a disabled edge with no mode change holds the state;
- a mode change reloads the first element;
- the 6-to-1 step of the permutation happens.

Only the bench scenarios can show the following:
- the complete visiting order of each sequence, and its wrap;
- the reset values in both modes;
- the start flag;
- no change at rising edges.

Recovery from unused codes cannot be reached through the ports. The bench therefore sweeps all sixteen codes through both next-state modules directly.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int SEQ_W   = 4;
  localparam int PERM_W  = 3;
  localparam logic MODE_PERM = 1'b0;
  localparam logic MODE_EVEN = 1'b1;
  localparam logic [SEQ_W-1:0] PERM_FIRST = SEQ_W'(6);
  localparam logic [SEQ_W-1:0] EVEN_FIRST = SEQ_W'(0);

  function automatic logic [SEQ_W-1:0] first_state(logic mode);
    return (mode == MODE_EVEN) ? EVEN_FIRST : PERM_FIRST;
  endfunction
endpackage

// File: rtl/seq_perm_next.sv
// Permutation next state, expressed as JK set/clear terms per bit.
module seq_perm_next
  import seq_pkg::*;
(
  input  logic [SEQ_W-1:0] q_i,
  output logic [SEQ_W-1:0] next_o
);
  logic [PERM_W-1:0] tgt_lo;
  logic [SEQ_W-1:0]  tgt;
  logic [SEQ_W-1:0]  j, k;

  always_comb begin
    unique case (q_i[PERM_W-1:0])
      3'd1:    tgt_lo = 3'd2;
      3'd2:    tgt_lo = 3'd4;
      3'd3:    tgt_lo = 3'd5;
      3'd4:    tgt_lo = 3'd7;
      3'd5:    tgt_lo = 3'd6;
      3'd6:    tgt_lo = 3'd1;
      3'd7:    tgt_lo = 3'd3;
      default: tgt_lo = 3'd6; // unused code 0 recovers to the head
    endcase
    if (q_i[SEQ_W-1:PERM_W] != '0) tgt_lo = 3'd6;
    tgt = {{(SEQ_W-PERM_W){1'b0}}, tgt_lo};
  end

  for (genvar b = 0; b < SEQ_W; b++) begin : g_jk
    assign j[b]      = ~q_i[b] &  tgt[b];
    assign k[b]      =  q_i[b] & ~tgt[b];
    assign next_o[b] = (j[b] & ~q_i[b]) | (~k[b] & q_i[b]);
  end
endmodule

// File: rtl/seq_even_next.sv
// Stride-two next state, expressed as T toggle terms per bit.
// Odd codes step by one, even codes by two; both share the same toggles.
module seq_even_next
  import seq_pkg::*;
(
  input  logic [SEQ_W-1:0] q_i,
  output logic [SEQ_W-1:0] next_o
);
  logic [SEQ_W-1:0] t;

  for (genvar b = 0; b < SEQ_W; b++) begin : g_t
    if (b == 0) begin : g_b0
      assign t[b] = q_i[0];
    end else if (b == 1) begin : g_b1
      assign t[b] = 1'b1;
    end else begin : g_hi
      assign t[b] = &q_i[b-1:1];
    end
    assign next_o[b] = q_i[b] ^ t[b];
  end
endmodule

// File: rtl/seq_counter.sv
module seq_counter
  import seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  output logic [SEQ_W-1:0] state_o,
  output logic             start_o
);
  logic [SEQ_W-1:0] state_q, perm_nx, even_nx, step_nx;
  logic             mode_q;

  seq_perm_next u_perm (.q_i(state_q), .next_o(perm_nx));
  seq_even_next u_even (.q_i(state_q), .next_o(even_nx));

  assign step_nx = (mode_q == MODE_EVEN) ? even_nx : perm_nx;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= first_state(mode_i);
      mode_q  <= mode_i;
    end else begin
      mode_q <= mode_i;
      if (mode_i != mode_q)  state_q <= first_state(mode_i);
      else if (en_i)         state_q <= step_nx;
    end
  end

  assign state_o = state_q;
  assign start_o = (state_q == first_state(mode_q));

  // R1 R3
  perm_legal_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PERM) |=> (state_q != '0 && state_q[SEQ_W-1] == 1'b0));
  // R2 R4
  even_legal_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EVEN) |=> (state_q[0] == 1'b0));
  // R6
  hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!en_i && mode_i == mode_q) |=> $stable(state_q));
  // R7
  reload_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (mode_i != mode_q) |=> (state_q == first_state(mode_q)));
  // R1
  perm_head_step_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_PERM && mode_q == MODE_PERM && state_q == PERM_FIRST)
      |=> (state_q == SEQ_W'(1)));
endmodule

// File: tb/seq_counter_tb_top.sv
`timescale 1ns/1ps
module seq_counter_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       mode_i = 1'b0;
  logic [3:0] state_o;
  logic       start_o;
  logic [3:0] sweep_q = 4'd0;
  logic [3:0] perm_nx, even_nx;
  int n_chk = 0;
  int n_bad = 0;
  logic exp_mode;
  logic [3:0] exp_st;

  always #2.5 clk_i = ~clk_i;

  seq_counter dut_i (.clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
                     .state_o(state_o), .start_o(start_o));
  seq_perm_next u_perm_sw (.q_i(sweep_q), .next_o(perm_nx));
  seq_even_next u_even_sw (.q_i(sweep_q), .next_o(even_nx));

  function automatic logic [3:0] m_first(logic md);
    return md ? 4'd0 : 4'd6;
  endfunction

  function automatic logic [3:0] m_next(logic md, logic [3:0] s);
    int ord [7] = '{6, 1, 2, 4, 7, 3, 5};
    if (md) return s[0] ? 4'(s + 4'd1) : 4'(s + 4'd2);
    for (int i = 0; i < 7; i++)
      if (ord[i] == int'(s)) return 4'(ord[(i + 1) % 7]);
    return 4'd6;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // lands 1 ns after a rising edge, 1.5 ns before the active falling edge
  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  // one edge with the given inputs, then compare with the model
  task automatic step(logic en, logic md, string req);
    en_i = en; mode_i = md;
    if (md != exp_mode) exp_st = m_first(md);
    else if (en)        exp_st = m_next(exp_mode, exp_st);
    exp_mode = md;
    cyc();
    chk(req, state_o, exp_st);
    chk("R8", {3'b0, start_o}, {3'b0, exp_st == m_first(exp_mode)});
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    // R5: reset in mode 0
    cyc(); cyc();
    chk("R5", state_o, 4'd6);
    chk("R8", {3'b0, start_o}, 4'd1);
    rst_ni = 1'b1;
    exp_mode = 1'b0; exp_st = 4'd6;

    // R1: two full passes of the permutation
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0, "R1");

    // R9: no change around a rising edge
    en_i = 1'b1;
    @(negedge clk_i); #0.5;
    exp_st = state_o;
    @(posedge clk_i); #0.5;
    chk("R9", state_o, exp_st);
    exp_st = state_o;
    cyc();
    exp_st = m_next(1'b0, exp_st);
    chk("R9", state_o, exp_st);

    // R6: hold
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R6");

    // R7: mode change while disabled
    step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b1, "R6");

    // R2: two full passes of the even walk
    for (int i = 0; i < 17; i++) step(1'b1, 1'b1, "R2");

    // R7: change back while enabled
    step(1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, "R1");

    // R5: reset in mode 1, asynchronous
    mode_i = 1'b1; #0.3; rst_ni = 1'b0; #0.2;
    chk("R5", state_o, 4'd0);
    chk("R8", {3'b0, start_o}, 4'd1);
    cyc();
    rst_ni = 1'b1;
    exp_mode = 1'b1; exp_st = 4'd0;
    step(1'b1, 1'b1, "R2");

    // R3 R4: exhaustive next-state sweep
    for (int s = 0; s < 16; s++) begin
      sweep_q = 4'(s);
      #1;
      chk("R3", perm_nx, m_next(1'b0, 4'(s)));
      chk("R4", even_nx, m_next(1'b1, 4'(s)));
    end

    report();
  end
endmodule